// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block sits on the host side of an SPI NOR flash and carries out write jobs on its own. A client asks for one of three jobs with a single start strobe: program a run of bytes beginning at a given address, erase the sector that holds a given address, or erase the whole array. The sequencer then drives the serial bus in SPI mode 0 until the flash reports that the job has finished.

For every modifying command the sequencer first sends a one-byte write-enable frame. It breaks a long program run into chunks that never cross a 256-byte page. After each program or erase frame it reads the status register over and over until the write-in-progress bit is clear, and only then moves on to the next chunk or reports completion. Program data is not held inside the block. A one-cycle request strobe fetches each byte from a buffer outside the block, just before that byte goes out on the wire.

Top module: `spi_flash_pgm_seq`

## Requirements
- R1: While reset is held and right after it is released, cs_no is 1, sclk_o is 0, and busy_o, done_o and byte_req_o are all 0.
- R2: The bus runs in SPI mode 0. sclk_o is 0 whenever cs_no is 1. mosi_o changes only while sclk_o is low, and it carries each byte MSB first.
- R3: Every program, sector erase and bulk erase frame comes directly after its own one-byte frame of 06h. No other frame lies between the two.
- R4: A program frame is 02h, then the 24-bit address MSB first, then the data bytes in the order they were fetched.
- R5: A program run is split so that each chunk ends at the last byte of its 256-byte page or at the end of the run. A chunk never holds more than 256 bytes. Each chunk has its own write-enable frame and its own polling.
- R6: op_i selects the job: 0 is program, 1 is sector erase, 2 is bulk erase. A sector erase frame is D8h followed by the 24-bit address. A bulk erase frame is the single byte C7h.
- R7: After each program or erase frame, the block sends two-byte frames of 05h plus a dummy byte. It repeats them until bit 0 of the status byte returned on miso_i reads 0. Only then does it send any further frame or finish.
- R8: cs_no stays high for at least one SCLK period (2*CLK_DIV clock cycles) between any two frames.
- R9: busy_o rises in the cycle after an accepted start_i. done_o is a one-cycle pulse, and busy_o is 0 in the cycle after it. start_i is ignored while busy_o is 1, and it is also ignored when op_i is 3. A program request with len_i equal to 0 finishes with no frames at all.
- R10: byte_req_o pulses once for each data byte, so a job makes exactly len_i requests. byte_i must hold the requested byte in the clock cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a job |
| op_i | input | 2 | Job select: 0 program, 1 sector erase, 2 bulk erase, 3 none |
| addr_i | input | ADDR_W | Start address for program, or any address in the target sector |
| len_i | input | LEN_W | Number of bytes to program |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse when a job completes |
| byte_req_o | output | 1 | Request for the next program data byte |
| byte_i | input | 8 | Program data byte, valid the cycle after byte_req_o |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The sequencer state, the address counter and the remaining-byte counter each decide what goes into the next frame. So a wrong internal value shows up at the ports as a wrong byte within the very next frame. The bench model decodes every frame when chip select rises, which means an error is reported no later than one frame after it happens. A broken chunk calculation shows as a wrong frame length or address at the page edge, and a broken polling decision shows as a modifying frame sent while the modelled flash is still busy. Errors in the bus timing (clock idle level, data stability, deselect gap) are compared on every clock cycle.

// File: rtl/spi_flash_pgm_pkg.sv
package spi_flash_pgm_pkg;

  typedef enum logic [1:0] {
    JOB_PROG = 2'd0,
    JOB_SECT = 2'd1,
    JOB_BULK = 2'd2,
    JOB_NONE = 2'd3
  } job_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_CMD,
    ST_ADDR,
    ST_FETCH,
    ST_LOAD,
    ST_DATA,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_GAP,
    ST_DONE
  } state_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SECT = 8'hD8;
  localparam logic [7:0] OPC_BULK = 8'hC7;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] WIP_MASK = 8'h01;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             active_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic             sclk_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        sh_q     <= tx_i;
        bit_q    <= '0;
        div_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DIV_W'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            // rising edge: sample
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            // falling edge: present next bit
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[6:0], 1'b0};
            bit_q  <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

endmodule

// File: rtl/spi_chunk_planner.sv
module spi_chunk_planner #(
  parameter int LEN_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] offs_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  chunk_o
);

  localparam int ROOM_W = PAGE_W + 1;

  logic [ROOM_W-1:0] room;
  logic [LEN_W-1:0]  room_ext;

  assign room     = {1'b1, {PAGE_W{1'b0}}} - {1'b0, offs_i};
  assign room_ext = LEN_W'(room);
  assign chunk_o  = (rem_i < room_ext) ? rem_i : room_ext;

endmodule

// File: rtl/spi_flash_pgm_seq.sv
module spi_flash_pgm_seq
  import spi_flash_pgm_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int PAGE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              byte_req_o,
  input  logic [7:0]        byte_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int GAP_CYC    = 2 * CLK_DIV;
  localparam int GAP_W      = $clog2(GAP_CYC + 1);

  state_e            state_q, next_q;
  job_e              job_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  chunk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        data_q;
  logic              issued_q;
  logic              cs_q;
  logic [GAP_W-1:0]  gap_q;

  logic              eng_go;
  logic              eng_done;
  logic [7:0]        eng_tx;
  logic [7:0]        eng_rx;
  logic [7:0]        addr_byte;
  logic [LEN_W-1:0]  plan_len;
  logic              send_st;
  logic              still_busy;

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (eng_go),
    .tx_i   (eng_tx),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (eng_rx),
    .done_o (eng_done)
  );

  spi_chunk_planner #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_plan (
    .offs_i  (addr_q[PAGE_W-1:0]),
    .rem_i   (rem_q),
    .chunk_o (plan_len)
  );

  always_comb begin
    addr_byte = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (idx_q == IDX_W'(b)) addr_byte = addr_q[(ADDR_BYTES-1-b)*8 +: 8];
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WREN, ST_CMD, ST_ADDR, ST_DATA, ST_POLL_OP, ST_POLL_RD: send_st = 1'b1;
      default:                                                  send_st = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_WREN:    eng_tx = OPC_WREN;
      ST_CMD: begin
        unique case (job_q)
          JOB_PROG: eng_tx = OPC_PROG;
          JOB_SECT: eng_tx = OPC_SECT;
          default:  eng_tx = OPC_BULK;
        endcase
      end
      ST_ADDR:    eng_tx = addr_byte;
      ST_DATA:    eng_tx = data_q;
      ST_POLL_OP: eng_tx = OPC_RDSR;
      default:    eng_tx = 8'h00;
    endcase
  end

  assign eng_go     = send_st && !issued_q;
  assign still_busy = (eng_rx & WIP_MASK) != 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      next_q   <= ST_IDLE;
      job_q    <= JOB_PROG;
      addr_q   <= '0;
      rem_q    <= '0;
      chunk_q  <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      issued_q <= 1'b0;
      cs_q     <= 1'b1;
      gap_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && (job_e'(op_i) != JOB_NONE)) begin
            job_q  <= job_e'(op_i);
            addr_q <= addr_i;
            rem_q  <= len_i;
            if ((job_e'(op_i) == JOB_PROG) && (len_i == '0)) state_q <= ST_DONE;
            else                                             state_q <= ST_WREN;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          data_q  <= byte_i;
          state_q <= ST_DATA;
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            gap_q   <= '0;
            state_q <= next_q;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: begin
          if (eng_go) begin
            issued_q <= 1'b1;
            cs_q     <= 1'b0;
          end
          if (eng_done) begin
            issued_q <= 1'b0;
            unique case (state_q)
              ST_WREN: begin
                cs_q    <= 1'b1;
                chunk_q <= plan_len;
                state_q <= ST_GAP;
                next_q  <= ST_CMD;
              end
              ST_CMD: begin
                if (job_q == JOB_BULK) begin
                  cs_q    <= 1'b1;
                  state_q <= ST_GAP;
                  next_q  <= ST_POLL_OP;
                end else begin
                  idx_q   <= '0;
                  state_q <= ST_ADDR;
                end
              end
              ST_ADDR: begin
                if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
                  if (job_q == JOB_PROG) begin
                    state_q <= ST_FETCH;
                  end else begin
                    cs_q    <= 1'b1;
                    state_q <= ST_GAP;
                    next_q  <= ST_POLL_OP;
                  end
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
              ST_DATA: begin
                addr_q  <= addr_q + 1'b1;
                rem_q   <= rem_q - 1'b1;
                chunk_q <= chunk_q - 1'b1;
                if (chunk_q == LEN_W'(1)) begin
                  cs_q    <= 1'b1;
                  state_q <= ST_GAP;
                  next_q  <= ST_POLL_OP;
                end else begin
                  state_q <= ST_FETCH;
                end
              end
              ST_POLL_OP: state_q <= ST_POLL_RD;
              ST_POLL_RD: begin
                cs_q    <= 1'b1;
                state_q <= ST_GAP;
                if (still_busy)                            next_q <= ST_POLL_OP;
                else if ((job_q == JOB_PROG) && (rem_q != '0)) next_q <= ST_WREN;
                else                                       next_q <= ST_DONE;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign cs_no      = cs_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign byte_req_o = (state_q == ST_FETCH);

endmodule

// File: rtl/spi_flash_pgm_chk.sv
module spi_flash_pgm_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic byte_req_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);

  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int CNT_W   = $clog2(GAP_MIN + 1) + 1;

  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= CNT_W'(GAP_MIN);
    else if (cs_no) begin
      if (hi_cnt < CNT_W'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
    end else hi_cnt <= '0;
  end

  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_mosi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_cs_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= CNT_W'(GAP_MIN)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_busy_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_req_in_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> (busy_o && !cs_no));

endmodule

bind spi_flash_pgm_seq spi_flash_pgm_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .byte_req_o (byte_req_o),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no),
  .mosi_o     (mosi_o)
);

// File: tb/spi_flash_pgm_seq_bench.sv
`timescale 1ns/1ps
module spi_flash_pgm_seq_bench;

  localparam int CLK_DIV = 2;
  localparam int GAP_MIN = 2 * CLK_DIV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [23:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic [7:0]  byte_i = '0;
  logic        miso_i = 1'b0;
  logic        busy_o, done_o, byte_req_o, sclk_o, cs_no, mosi_o;

  always #2 clk_i = ~clk_i;

  spi_flash_pgm_seq #(.CLK_DIV(CLK_DIV)) u_spi_flash_pgm_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .addr_i(addr_i), .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
    .byte_req_o(byte_req_o), .byte_i(byte_i), .sclk_o(sclk_o),
    .cs_no(cs_no), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // flash-side model
  logic [7:0] cur[$];
  logic [7:0] exp_b[$];
  int         exp_n[$];
  int         bitc = 0;
  logic [7:0] sh = '0;
  logic [7:0] stat_byte = '0;
  int         polls_left = 0;
  int         poll_cfg = 0;
  bit         wel = 0;
  bit         in_frame = 0;

  task automatic frame_end();
    int n;
    int off;
    string tag;
    logic [7:0] e[$];
    in_frame = 0;
    miso_i = 1'b0;
    if (exp_n.size() == 0) begin
      check(0, "R3 unexpected frame", (cur.size() > 0) ? int'(cur[0]) : 0, 0);
    end else begin
      n = exp_n.pop_front();
      e.delete();
      repeat (n) e.push_back(exp_b.pop_front());
      case (e[0])
        8'h06:   tag = "R3";
        8'h02:   tag = "R4";
        8'h05:   tag = "R7";
        default: tag = "R6";
      endcase
      check(cur.size() == n, {tag, " frame length"}, cur.size(), n);
      for (int i = 0; i < n && i < cur.size(); i++)
        if (!(e[0] == 8'h05 && i > 0))
          check(cur[i] == e[i], {tag, " frame byte"}, int'(cur[i]), int'(e[i]));
    end
    if (cur.size() > 0) begin
      case (cur[0])
        8'h06: wel = 1;
        8'h02, 8'hD8, 8'hC7: begin
          check(wel, "R3 write enable before command", wel, 1);
          check(polls_left == 0, "R7 command while flash busy", polls_left, 0);
          wel = 0;
          polls_left = poll_cfg;
          if (cur[0] == 8'h02 && cur.size() >= 4) begin
            off = int'(cur[3]);
            check(off + cur.size() - 4 <= 256, "R5 page boundary", off + cur.size() - 4, 256);
          end
        end
        8'h05: if (polls_left > 0) polls_left--;
        default: ;
      endcase
    end
  endtask

  initial forever begin
    @(negedge cs_no);
    in_frame = 1;
    cur.delete();
    bitc = 0;
  end

  initial forever begin
    @(posedge cs_no);
    if (in_frame) frame_end();
  end

  initial forever begin
    @(posedge sclk_o);
    if (!cs_no) begin
      sh = {sh[6:0], mosi_o};
      bitc++;
      if (bitc % 8 == 0) begin
        cur.push_back(sh);
        if (bitc == 8) stat_byte = {7'b0, (polls_left > 0)};
      end
    end
  end

  initial forever begin
    @(negedge sclk_o);
    if (!cs_no && bitc >= 8 && cur.size() > 0 && cur[0] == 8'h05)
      miso_i = stat_byte[7 - ((bitc - 8) % 8)];
  end

  // per-clock comparison and data buffer
  int   hi_cnt = 1000;
  int   req_cnt = 0;
  int   done_cnt = 0;
  bit   prev_done = 0;
  bit   prev_cs = 1;
  bit   prev_sclk = 0;
  logic prev_mosi = 1'b0;

  initial begin
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      check(!(cs_no && sclk_o), "R2 sclk idle low", sclk_o, 0);
      if (prev_sclk && sclk_o) check(mosi_o == prev_mosi, "R2 mosi stable", mosi_o, prev_mosi);
      prev_sclk = sclk_o;
      prev_mosi = mosi_o;
      if (cs_no) hi_cnt++;
      else begin
        if (prev_cs) check(hi_cnt >= GAP_MIN, "R8 cs gap", hi_cnt, GAP_MIN);
        hi_cnt = 0;
      end
      prev_cs = cs_no;
      if (byte_req_o) begin
        byte_i = pat(req_cnt);
        req_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        check(!prev_done, "R9 done single pulse", 1, 0);
      end
      prev_done = done_o;
    end
  end

  int exp_req = 0;

  task automatic push_polls(int p);
    repeat (p + 1) begin
      exp_b.push_back(8'h05);
      exp_b.push_back(8'h00);
      exp_n.push_back(2);
    end
  endtask

  task automatic build(int op, int a, int len, int p);
    int rem, ad, k, n;
    if (op == 0) begin
      rem = len; ad = a; k = exp_req;
      while (rem > 0) begin
        n = 256 - (ad % 256);
        if (n > rem) n = rem;
        exp_b.push_back(8'h06); exp_n.push_back(1);
        exp_b.push_back(8'h02);
        exp_b.push_back(8'(ad >> 16));
        exp_b.push_back(8'(ad >> 8));
        exp_b.push_back(8'(ad));
        for (int i = 0; i < n; i++) exp_b.push_back(pat(k + i));
        exp_n.push_back(4 + n);
        push_polls(p);
        k += n; ad += n; rem -= n;
      end
      exp_req = k;
    end else if (op == 1) begin
      exp_b.push_back(8'h06); exp_n.push_back(1);
      exp_b.push_back(8'hD8);
      exp_b.push_back(8'(a >> 16));
      exp_b.push_back(8'(a >> 8));
      exp_b.push_back(8'(a));
      exp_n.push_back(4);
      push_polls(p);
    end else begin
      exp_b.push_back(8'h06); exp_n.push_back(1);
      exp_b.push_back(8'hC7); exp_n.push_back(1);
      push_polls(p);
    end
  endtask

  task automatic run_job(int op, int a, int len, int p, bit poke);
    int d0, r0, waited;
    d0 = done_cnt; r0 = req_cnt; waited = 0;
    poll_cfg = p;
    build(op, a, len, p);
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'(op); addr_i = 24'(a); len_i = 16'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    if (poke) begin
      repeat (40) @(negedge clk_i);
      start_i = 1'b1; op_i = 2'd2; addr_i = 24'h123456; len_i = 16'd9;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (done_cnt == d0 && waited < 100000) begin
      @(negedge clk_i);
      waited++;
    end
    check(done_cnt == d0 + 1, "R9 done seen", done_cnt - d0, 1);
    @(negedge clk_i);
    check(busy_o == 1'b0, "R9 busy falls after done", busy_o, 0);
    check(exp_n.size() == 0, "R7 expected frames left", exp_n.size(), 0);
    check(req_cnt - r0 == len, "R10 byte request count", req_cnt - r0, len);
  endtask

  task automatic reset_state(string when);
    check(cs_no == 1'b1, {"R1 cs_no ", when}, cs_no, 1);
    check(sclk_o == 1'b0, {"R1 sclk_o ", when}, sclk_o, 0);
    check(busy_o == 1'b0, {"R1 busy_o ", when}, busy_o, 0);
    check(done_o == 1'b0, {"R1 done_o ", when}, done_o, 0);
    check(byte_req_o == 1'b0, {"R1 byte_req_o ", when}, byte_req_o, 0);
  endtask

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk_i);
    reset_state("in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    reset_state("after reset");

    run_job(0, 24'h000010, 4, 2, 0);      // R4 single chunk
    run_job(0, 24'h0001FE, 5, 1, 0);      // R5 split 2 + 3
    run_job(1, 24'h030000, 0, 3, 1);      // R6 sector, R9 start ignored while busy
    run_job(2, 24'h000000, 0, 5, 0);      // R6 bulk, R7 long poll
    run_job(0, 24'h000400, 260, 0, 0);    // R5 full page then tail
    run_job(0, 24'h0008FF, 2, 1, 0);      // R5 last byte of page
    run_job(0, 24'h0000FF, 0, 1, 0);      // R9 zero length

    // R9: op 3 is ignored
    d0 = done_cnt;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd3;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) begin
      check(busy_o == 1'b0, "R9 op 3 ignored busy", busy_o, 0);
      check(cs_no == 1'b1, "R9 op 3 ignored cs", cs_no, 1);
      @(negedge clk_i);
    end
    check(done_cnt == d0, "R9 op 3 no done", done_cnt - d0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule